// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Controller

This block gives software control over up to 32 general-purpose pins through a small 32-bit register bus. The bus has a byte address, a write strobe, write data and combinational read data. Each pin is set as an input or an output. An output register drives the outputs, and reading the level register returns the synchronized pin state. Every pin passes through a two-flop synchronizer before any edge or level is evaluated.

Each pin has its own trigger setting, built from three bit planes:
- a mode bit chooses level or edge;
- a sense bit chooses which level or which edge;
- a dual-edge bit, in edge mode, accepts both edges and overrides the sense bit.

Detected events latch into a status register. Writing ones to a clear register removes latched events. The pending view is status masked by the per-pin enables, and a single interrupt line is the OR of the pending bits. A version word of 3 tells software that dual-edge detection is present.

Register offsets (byte address, bits [5:2] select the word):

| Offset | Register |
|--------|----------|
| 0x00 | level / output |
| 0x04 | direction |
| 0x08 | enable |
| 0x0C | status |
| 0x10 | pending |
| 0x14 | clear |
| 0x18 | mode |
| 0x1C | sense |
| 0x20 | version |
| 0x24 | dual-edge |

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset these registers hold all ones: direction (0x04), mode (0x18) and sense (0x1C). These hold zero: output value, enable (0x08), status (0x0C), pending (0x10) and dual-edge (0x24). As a result, pin_oe and irq are 0.
- R2: A direction bit of 1 makes the pin an input (pin_oe bit 0). A direction bit of 0 makes it an output (pin_oe bit 1). pin_out always equals the value last written to offset 0x00.
- R3: A read of offset 0x00 returns, for input pins, the pin level captured through two flops: a pin change is visible after the second rising clock edge. For output pins it returns the output register.
- R4: With mode bit 0 the pin is level-triggered. Sense 1 is active-high and sense 0 is active-low. While the level stays active, the status bit stays set even when it is cleared.
- R5: With mode bit 1 and dual-edge bit 0, sense 1 latches rising edges and sense 0 latches falling edges.
- R6: With mode bit 1 and dual-edge bit 1, both edges latch and the sense bit is ignored.
- R7: Offset 0x20 reads 3, and writes to it are ignored. Unmapped or misaligned addresses (bus_addr[1:0] not 0) read 0 and ignore writes.
- R8: Writing a 1 to bit i of offset 0x14 clears status bit i. A 0 bit leaves the status bit unchanged. Writes to offset 0x0C are ignored.
- R9: Offset 0x10 reads status AND enable. irq is 1 exactly when that value is nonzero.
- R10: A clear that meets a new event on the same pin in the same cycle leaves the status bit set.
- R11: An edge on a pin becomes visible in status, pending and irq after the third rising clock edge after the pin change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Output levels |
| pin_oe | output | NUM_PINS | Output enable per pin, 1 = drive |
| irq | output | 1 | Combined interrupt |

## Verification
Timing of each result after its stimulus:
- Register writes show on the read port, pin_out and pin_oe one edge after the strobe is sampled.
- A pin change reaches the level readback after two edges.
- A pin change reaches status, pending and irq after three edges.
- A clear takes effect on the edge that samples it.

The bench drives stimulus a quarter period after each rising edge and samples at the next falling edge. A reference model advances on every rising edge. It keeps a three-deep history of sampled pin values and evaluates events from the two older entries. Every clock, the model is compared with irq, pin_out, pin_oe and the word at the current address. Directed checks read one cycle early to confirm the two-edge readback latency and the three-edge status latency. The same-cycle clear is timed so that the write is sampled on the exact edge where the edge event latches.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [3:0] {
    REG_LEVEL = 4'h0,
    REG_DIR   = 4'h1,
    REG_IEN   = 4'h2,
    REG_STS   = 4'h3,
    REG_PEND  = 4'h4,
    REG_CLR   = 4'h5,
    REG_MODE  = 4'h6,
    REG_SENSE = 4'h7,
    REG_VER   = 4'h8,
    REG_DUAL  = 4'h9
  } reg_idx_e;

  localparam logic [31:0] VERSION_CODE = 32'd3;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] mode_i,
  input  logic [W-1:0] sense_i,
  input  logic [W-1:0] dual_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] event_c;
  logic [W-1:0] status_d;
  logic [W-1:0] status_q;

  for (genvar gi = 0; gi < W; gi++) begin : g_pin
    logic rise_c, fall_c, edge_hit_c;
    assign rise_c     = lvl_i[gi] & ~prev_q[gi];
    assign fall_c     = ~lvl_i[gi] & prev_q[gi];
    assign edge_hit_c = dual_i[gi] ? (rise_c | fall_c)
                                   : (sense_i[gi] ? rise_c : fall_c);
    assign event_c[gi] = mode_i[gi] ? edge_hit_c : (lvl_i[gi] == sense_i[gi]);

    a_r10_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      event_c[gi] |=> status_q[gi]);
    a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[gi] && !event_c[gi]) |=> !status_q[gi]);
    a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[gi] && !event_c[gi]) |=> $stable(status_q[gi]));
    a_r6_dual_any_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i[gi] && dual_i[gi] && (lvl_i[gi] != prev_q[gi])) |=> status_q[gi]);
    a_r4_level_active: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_i[gi] && (lvl_i[gi] == sense_i[gi])) |=> status_q[gi]);
  end

  always_comb begin
    status_d = event_c | (status_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= lvl_i;
      status_q <= status_d;
    end
  end

  assign status_o = status_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [5:0]          bus_addr,
  input  logic                bus_we,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);
  localparam int N = NUM_PINS;

  logic [3:0]   word_idx;
  logic         aligned;
  logic [N-1:0] wr_bits;
  logic         wr_val, wr_dir, wr_ien, wr_mode, wr_sense, wr_dual;
  logic [N-1:0] clr_vec;

  logic [N-1:0] val_q, val_d, dir_q, dir_d, ien_q, ien_d;
  logic [N-1:0] mode_q, mode_d, sense_q, sense_d, dual_q, dual_d;
  logic [N-1:0] lvl_sync, status, pending;

  assign word_idx = bus_addr[5:2];
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign wr_bits  = bus_wdata[N-1:0];

  always_comb begin
    wr_val   = bus_we && aligned && (word_idx == REG_LEVEL);
    wr_dir   = bus_we && aligned && (word_idx == REG_DIR);
    wr_ien   = bus_we && aligned && (word_idx == REG_IEN);
    wr_mode  = bus_we && aligned && (word_idx == REG_MODE);
    wr_sense = bus_we && aligned && (word_idx == REG_SENSE);
    wr_dual  = bus_we && aligned && (word_idx == REG_DUAL);
    clr_vec  = (bus_we && aligned && (word_idx == REG_CLR)) ? wr_bits : '0;
  end

  always_comb begin
    val_d   = val_q;
    dir_d   = dir_q;
    ien_d   = ien_q;
    mode_d  = mode_q;
    sense_d = sense_q;
    dual_d  = dual_q;
    if (wr_val)   val_d   = wr_bits;
    if (wr_dir)   dir_d   = wr_bits;
    if (wr_ien)   ien_d   = wr_bits;
    if (wr_mode)  mode_d  = wr_bits;
    if (wr_sense) sense_d = wr_bits;
    if (wr_dual)  dual_d  = wr_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q   <= '0;
      dir_q   <= '1;
      ien_q   <= '0;
      mode_q  <= '1;
      sense_q <= '1;
      dual_q  <= '0;
    end else begin
      val_q   <= val_d;
      dir_q   <= dir_d;
      ien_q   <= ien_d;
      mode_q  <= mode_d;
      sense_q <= sense_d;
      dual_q  <= dual_d;
    end
  end

  gpio_irq_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (lvl_sync)
  );

  gpio_irq_detect #(.W(N)) u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl_i    (lvl_sync),
    .mode_i   (mode_q),
    .sense_i  (sense_q),
    .dual_i   (dual_q),
    .clr_i    (clr_vec),
    .status_o (status)
  );

  assign pending = status & ien_q;
  assign irq     = |pending;
  assign pin_out = val_q;
  assign pin_oe  = ~dir_q;

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (word_idx)
        REG_LEVEL: bus_rdata = 32'((dir_q & lvl_sync) | (~dir_q & val_q));
        REG_DIR:   bus_rdata = 32'(dir_q);
        REG_IEN:   bus_rdata = 32'(ien_q);
        REG_STS:   bus_rdata = 32'(status);
        REG_PEND:  bus_rdata = 32'(pending);
        REG_MODE:  bus_rdata = 32'(mode_q);
        REG_SENSE: bus_rdata = 32'(sense_q);
        REG_VER:   bus_rdata = VERSION_CODE;
        REG_DUAL:  bus_rdata = 32'(dual_q);
        default:   bus_rdata = '0;
      endcase
    end
  end

  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((status & ien_q) != '0));
  a_r2_oe_after_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (pin_oe == ~$past(wr_bits)));
endmodule

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
  localparam int N = 32;
  localparam time TCLK = 20ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [5:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pin_out;
  logic [N-1:0]  pin_oe;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  always #(TCLK/2) clk = ~clk;

  gpio_irq_ctrl u_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // reference model state
  logic [31:0] m_val, m_dir, m_ien, m_sts, m_mode, m_sense, m_dual;
  logic [31:0] hist[3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_val = 0; m_dir = '1; m_ien = 0; m_sts = 0;
      m_mode = '1; m_sense = '1; m_dual = 0;
      for (int k = 0; k < 3; k++) hist[k] = 0;
    end else begin
      logic [31:0] clr;
      logic [31:0] ev;
      clr = 0;
      for (int i = 0; i < N; i++) begin
        logic now_v, old_v, r, f;
        now_v = hist[1][i];
        old_v = hist[2][i];
        r = now_v && !old_v;
        f = !now_v && old_v;
        if (!m_mode[i]) ev[i] = (now_v == m_sense[i]);
        else if (m_dual[i]) ev[i] = r || f;
        else ev[i] = m_sense[i] ? r : f;
      end
      if (bus_we && bus_addr[1:0] == 0) begin
        case (bus_addr[5:2])
          4'd0: m_val = bus_wdata;
          4'd1: m_dir = bus_wdata;
          4'd2: m_ien = bus_wdata;
          4'd5: clr = bus_wdata;
          4'd6: m_mode = bus_wdata;
          4'd7: m_sense = bus_wdata;
          4'd9: m_dual = bus_wdata;
          default: ;
        endcase
      end
      for (int i = 0; i < N; i++)
        m_sts[i] = ev[i] ? 1'b1 : (clr[i] ? 1'b0 : m_sts[i]);
      hist[2] = hist[1];
      hist[1] = hist[0];
      hist[0] = pin_in;
    end
  end

  function automatic logic [31:0] model_read(input logic [5:0] a);
    if (a[1:0] != 0) return 0;
    case (a[5:2])
      4'd0: return (m_dir & hist[1]) | (~m_dir & m_val);
      4'd1: return m_dir;
      4'd2: return m_ien;
      4'd3: return m_sts;
      4'd4: return m_sts & m_ien;
      4'd6: return m_mode;
      4'd7: return m_sense;
      4'd8: return 32'd3;
      4'd9: return m_dual;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] a);
    case (a[5:2])
      4'd0: return "R3";
      4'd3: return "R8";
      4'd4: return "R9";
      4'd8: return "R7";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      check("R9 irq", {31'd0, irq}, {31'd0, |(m_sts & m_ien)});
      check("R2 pin_out", pin_out, m_val);
      check("R2 pin_oe", pin_oe, ~m_dir);
      check(tag_of(bus_addr), bus_rdata, model_read(bus_addr));
    end
  end

  task automatic step();
    @(posedge clk); #5;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    step();
    bus_we = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [5:0] a, input logic [31:0] exp);
    bus_addr = a;
    #4;
    check(tag, bus_rdata, exp);
    step();
  endtask

  initial begin
    #(TCLK * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) step();
    rst_n = 1'b1;
    step();
    mon_on = 1'b1;

    // R1 reset values
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 pin_oe", pin_oe, 32'd0);
    rd_check("R1 dir", 6'h04, 32'hFFFF_FFFF);
    rd_check("R1 enable", 6'h08, 32'd0);
    rd_check("R1 status", 6'h0C, 32'd0);
    rd_check("R1 pending", 6'h10, 32'd0);
    rd_check("R1 mode", 6'h18, 32'hFFFF_FFFF);
    rd_check("R1 sense", 6'h1C, 32'hFFFF_FFFF);
    rd_check("R1 dual", 6'h24, 32'd0);

    // R7 version and unmapped space
    wr(6'h20, 32'h55);
    rd_check("R7 version", 6'h20, 32'd3);
    rd_check("R7 unmapped", 6'h2C, 32'd0);
    rd_check("R7 misaligned", 6'h21, 32'd0);
    wr(6'h0C, 32'hFFFF_FFFF);
    rd_check("R8 status read-only", 6'h0C, 32'd0);

    // R2 direction and outputs
    wr(6'h04, 32'hFFFF_0000);
    wr(6'h00, 32'h1234_ABCD);
    check("R2 pin_out", pin_out, 32'h1234_ABCD);
    check("R2 pin_oe", pin_oe, 32'h0000_FFFF);

    // R3 readback latency, R11 status latency, R5 rising default
    pin_in = 32'hA5A5_FFFF;
    step();
    rd_check("R3 one edge not visible", 6'h00, 32'h0000_ABCD);
    rd_check("R3 two edges visible", 6'h00, 32'hA5A5_ABCD);
    rd_check("R11 status after three edges", 6'h0C, 32'hA5A5_FFFF);
    wr(6'h14, 32'd0);
    rd_check("R8 zero clear no effect", 6'h0C, 32'hA5A5_FFFF);
    wr(6'h14, 32'hFFFF_FFFF);
    rd_check("R8 clear all", 6'h0C, 32'd0);

    // R4 level configuration
    pin_in = 32'd0;
    for (int k = 0; k < 4; k++) step();
    wr(6'h0C + 6'h0C, 32'hFFFC_FFFF);   // mode at 0x18: pins 16,17 level
    wr(6'h1C, 32'hFFE5_FFFF);           // sense: 17,19,20 low
    wr(6'h24, 32'h0030_0000);           // dual: 20,21
    wr(6'h08, 32'hFFFF_FFFF);
    for (int k = 0; k < 3; k++) step();
    wr(6'h14, 32'hFFFF_FFFF);
    rd_check("R4 active-low level stays after clear", 6'h0C, 32'h0002_0000);
    check("R9 irq from level", {31'd0, irq}, 32'd1);
    pin_in = 32'h0003_0000;
    for (int k = 0; k < 3; k++) step();
    wr(6'h14, 32'hFFFF_FFFF);
    rd_check("R4 active-high stays, inactive low cleared", 6'h0C, 32'h0001_0000);

    // R5 / R6 edges
    pin_in = 32'h003F_0000;
    for (int k = 0; k < 3; k++) step();
    rd_check("R5 R6 rising edges", 6'h0C, 32'h0035_0000);
    wr(6'h14, 32'h0034_0000);
    pin_in = 32'h0003_0000;
    for (int k = 0; k < 3; k++) step();
    rd_check("R5 R6 falling edges", 6'h0C, 32'h0039_0000);

    // R9 pending masking
    wr(6'h08, 32'h0008_0000);
    rd_check("R9 pending masked", 6'h10, 32'h0008_0000);
    check("R9 irq one enabled", {31'd0, irq}, 32'd1);
    wr(6'h08, 32'd0);
    rd_check("R9 pending none", 6'h10, 32'd0);
    check("R9 irq none", {31'd0, irq}, 32'd0);

    // R10 clear in the same cycle as an edge
    wr(6'h14, 32'hFFFF_FFFF);
    pin_in = 32'h0007_0000;
    step();
    step();
    wr(6'h14, 32'h0004_0000);
    rd_check("R10 same-cycle clear keeps bit", 6'h0C, 32'h0005_0000);
    wr(6'h14, 32'h0004_0000);
    rd_check("R8 later clear drops bit", 6'h0C, 32'h0001_0000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule